// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block computes the product y = A·x of an N×N signed matrix and an N-element signed vector on a one-dimensional chain of N identical cells. Before streaming, each cell is given one vector element through a small indexed load port, and that element stays in the cell. Matrix rows are then presented on a bus with one lane per cell. The feed is skewed: element (i, j) appears on lane j one cycle later than element (i, j-1). A partial sum for each row starts at zero at the first cell and moves one cell per clock. Each cell adds its lane value times its stored vector element to the partial sum.

The finished sum for a row leaves the last cell N clock edges after the row's first element entered. Rows fed on back-to-back cycles therefore produce results on back-to-back cycles. A valid bit travels with each partial sum and marks the cycles that carry a result. Matrix storage and the memory that produces the skewed feed sit outside the block, so any lane value that no row is due to use is simply ignored. Reset is asserted asynchronously and released through a two-flop synchroniser. N must be at least 2.

Top module: `sysmv_array`

## Requirements
- R1: For every row i, the result equals the signed sum over j of a[i][j]·x[j]. The result is two's complement, ACC_W = 2·DATA_W + clog2(N_CELLS) bits wide, so no input combination can overflow it (N=4 with every operand at -128 gives 65536).
- R2: Lane j of `a_lanes` (bits [j·DATA_W +: DATA_W], lane 0 feeding the first cell) is sampled for row i on edge s+j, where s is the edge on which `row_valid` is high with that row's element on lane 0.
- R3: A row whose first element is sampled on edge s appears on `y_data` with `y_valid` high right after edge s+N-1, and after no other edge.
- R4: Rows sampled on consecutive edges 1..N produce results after consecutive edges N..2N-1.
- R5: After any edge that completes no row, `y_valid` is low and `y_data` keeps the last result. Gaps between rows are allowed.
- R6: A lane value in a cycle where no row is due at that lane's cell has no effect on any result.
- R7: With `vec_load` high, the edge writes `vec_data` into the cell selected by `vec_idx`. A matrix element entering that cell on the same edge still uses the old value, and elements entering on later edges use the new one.
- R8: Reset clears every stored vector element to zero, and it drives `y_valid` and `y_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_load | input | 1 | Write one vector element this edge |
| vec_idx | input | IDX_W | Cell receiving the element |
| vec_data | input | DATA_W | Signed vector element |
| row_valid | input | 1 | A new row starts on lane 0 this edge |
| a_lanes | input | N_CELLS·DATA_W | Skewed matrix elements, one lane per cell |
| y_valid | output | 1 | `y_data` holds a fresh result |
| y_data | output | ACC_W | Signed result for one row |

## Verification
Two functions can fall in the same cycle: a vector element can be reloaded while rows are still streaming, and a matrix element can enter that same cell on the same edge. The bench issues a load to an inner cell at the exact edge where a mid-stream row reaches that cell. Its model splits the rows at that edge, so the earlier rows use the old vector element and the later rows use the new one, and every output cycle is compared against that split. Random values on unscheduled lanes and gaps between rows show that only the scheduled diagonal contributes.

// File: rtl/sysmv_pkg.sv
package sysmv_pkg;

  // Width of a partial sum that cannot overflow for n products of dw-bit operands.
  function automatic int sum_width(input int dw, input int n);
    return 2 * dw + ((n > 1) ? $clog2(n) : 0);
  endfunction

  function automatic int index_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sysmv_xload.sv
module sysmv_xload #(
  parameter int N_CELLS = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_load,
  input  logic [IDX_W-1:0]   vec_idx,
  output logic [N_CELLS-1:0] cell_we
);

  always_comb begin
    cell_we = '0;
    for (int k = 0; k < N_CELLS; k++) begin
      if (vec_load && (32'(vec_idx) == k)) cell_we[k] = 1'b1;
    end
  end

  // R7: a load in range enables exactly one cell; no load enables none
  assert_one_cell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_load && (32'(vec_idx) < N_CELLS)) |-> $onehot(cell_we));
  assert_no_stray_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_load |-> (cell_we == '0));

endmodule

// File: rtl/sysmv_cell.sv
module sysmv_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_we,
  input  logic [DATA_W-1:0] x_din,
  input  logic [DATA_W-1:0] a_in,
  input  logic [ACC_W-1:0]  sum_in,
  input  logic              vld_in,
  output logic [ACC_W-1:0]  sum_out,
  output logic              vld_out
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic [DATA_W-1:0] x_q, x_d;
  logic [ACC_W-1:0]  sum_q, sum_d;
  logic              vld_q, vld_d;
  logic              sum_en;
  logic [PROD_W-1:0] a_ext, x_ext, prod;

  // next-state
  always_comb begin
    a_ext  = {{DATA_W{a_in[DATA_W-1]}}, a_in};
    x_ext  = {{DATA_W{x_q[DATA_W-1]}}, x_q};
    prod   = a_ext * x_ext;
    sum_en = vld_in;
    vld_d  = vld_in;
    x_d    = x_we ? x_din : x_q;
    sum_d  = sum_q;
    if (sum_en) sum_d = sum_in + {{EXT_W{prod[PROD_W-1]}}, prod};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      x_q   <= x_d;
      sum_q <= sum_d;
      vld_q <= vld_d;
    end
  end

  assign sum_out = sum_q;
  assign vld_out = vld_q;

  // R3: the valid bit moves exactly one cell per edge
  assert_vld_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_out);
  assert_vld_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> !vld_out);
  // R5: without an arriving row the partial sum holds
  assert_sum_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> $stable(sum_out));
  // R7: the stored vector element changes only on a write
  assert_x_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !x_we |=> $stable(x_q));

endmodule

// File: rtl/sysmv_array.sv
module sysmv_array #(
  parameter  int N_CELLS = 4,
  parameter  int DATA_W  = 8,
  localparam int ACC_W   = sysmv_pkg::sum_width(DATA_W, N_CELLS),
  localparam int IDX_W   = sysmv_pkg::index_width(N_CELLS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vec_load,
  input  logic [IDX_W-1:0]            vec_idx,
  input  logic [DATA_W-1:0]           vec_data,
  input  logic                        row_valid,
  input  logic [N_CELLS*DATA_W-1:0]   a_lanes,
  output logic                        y_valid,
  output logic [ACC_W-1:0]            y_data
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_CELLS-1:0] cell_we;
  logic [ACC_W-1:0]   sum_link [0:N_CELLS];
  logic               vld_link [0:N_CELLS];

  assign sum_link[0] = '0;
  assign vld_link[0] = row_valid;

  sysmv_xload #(
    .N_CELLS (N_CELLS),
    .IDX_W   (IDX_W)
  ) u_xload (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .vec_load (vec_load),
    .vec_idx  (vec_idx),
    .cell_we  (cell_we)
  );

  for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
    sysmv_cell #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .x_we    (cell_we[j]),
      .x_din   (vec_data),
      .a_in    (a_lanes[j*DATA_W +: DATA_W]),
      .sum_in  (sum_link[j]),
      .vld_in  (vld_link[j]),
      .sum_out (sum_link[j+1]),
      .vld_out (vld_link[j+1])
    );
  end

  assign y_valid = vld_link[N_CELLS];
  assign y_data  = sum_link[N_CELLS];

  // R5: the result port only changes on a cycle that carries a result
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !y_valid |-> $stable(y_data) || $rose(y_valid) || $past(y_valid));

endmodule

// File: tb/tb_sysmv_array.sv
module tb_sysmv_array;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2 * DW + 2;
  localparam int IW = 2;
  localparam int MAXR = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              vec_load;
  logic [IW-1:0]     vec_idx;
  logic [DW-1:0]     vec_data;
  logic              row_valid;
  logic [N*DW-1:0]   a_lanes;
  logic              y_valid;
  logic [AW-1:0]     y_data;

  always #4 clk = ~clk;

  sysmv_array #(.N_CELLS(N), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .vec_load(vec_load), .vec_idx(vec_idx),
    .vec_data(vec_data), .row_valid(row_valid), .a_lanes(a_lanes),
    .y_valid(y_valid), .y_data(y_data)
  );

  int     tests = 0, fails = 0, edges = 0;
  int     exp_due[$];
  longint exp_val[$];
  longint last_y = 0;
  int     xm [N];
  int     A  [MAXR][N];
  int     rs [MAXR];
  int     nrows = 0;
  int     ld_cyc = -1, ld_idx = 0, ld_val = 0;

  always @(posedge clk) edges++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_now(input string tag);
    longint ys;
    ys = longint'($signed(y_data));
    if (exp_due.size() > 0 && exp_due[0] == edges) begin
      check(y_valid == 1'b1, "R3", longint'(y_valid), 1);
      check(ys == exp_val[0], tag, ys, exp_val[0]);
      last_y = exp_val[0];
      void'(exp_due.pop_front());
      void'(exp_val.pop_front());
    end else begin
      check(y_valid == 1'b0, "R5", longint'(y_valid), 0);
      check(ys == last_y, "R5", ys, last_y);
    end
  endtask

  task automatic load_x(input int idx, input int val, input string tag);
    @(negedge clk);
    compare_now(tag);
    row_valid = 1'b0;
    vec_load  = 1'b1;
    vec_idx   = IW'(idx);
    vec_data  = DW'(val);
    xm[idx]   = val;
  endtask

  task automatic run_stream(input string tag);
    longint acc [MAXR];
    int last;
    last = rs[nrows-1] + N - 1;
    for (int i = 0; i < MAXR; i++) acc[i] = 0;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      compare_now(tag);
      row_valid = 1'b0;
      vec_load  = 1'b0;
      for (int j = 0; j < N; j++) begin
        a_lanes[j*DW +: DW] = DW'($urandom);  // R6: off-schedule lanes get noise
        for (int i = 0; i < nrows; i++) begin
          if (rs[i] + j == c) begin
            a_lanes[j*DW +: DW] = DW'(A[i][j]);
            acc[i] += longint'(A[i][j]) * longint'(xm[j]);
            if (j == 0) row_valid = 1'b1;
            if (j == N - 1) begin
              exp_due.push_back(edges + 1);
              exp_val.push_back(acc[i]);
            end
          end
        end
      end
      if (c == ld_cyc) begin
        vec_load = 1'b1;
        vec_idx  = IW'(ld_idx);
        vec_data = DW'(ld_val);
        xm[ld_idx] = ld_val;
      end
    end
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      compare_now(tag);
      row_valid = 1'b0;
      vec_load  = 1'b0;
      a_lanes   = N*DW'($urandom);
    end
    ld_cyc = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(y_valid == 1'b0, "R8", longint'(y_valid), 0);
    check(y_data == '0, "R8", longint'($signed(y_data)), 0);
    for (int j = 0; j < N; j++) xm[j] = 0;
    last_y = 0;
    exp_due.delete();
    exp_val.delete();
    repeat (2) @(negedge clk);
    check(y_valid == 1'b0 && y_data == '0, "R8", longint'($signed(y_data)), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vec_load = 1'b0; vec_idx = '0; vec_data = '0;
    row_valid = 1'b0; a_lanes = '0;
    for (int j = 0; j < N; j++) xm[j] = 0;
    repeat (3) @(negedge clk);
    check(y_valid == 1'b0, "R8", longint'(y_valid), 0);
    check(y_data == '0, "R8", longint'($signed(y_data)), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R4: contiguous rows, mixed signs
    load_x(0, 3, "R7"); load_x(1, -2, "R7"); load_x(2, 5, "R7"); load_x(3, 7, "R7");
    nrows = 4;
    for (int i = 0; i < 4; i++) begin
      rs[i] = i;
      for (int j = 0; j < N; j++) A[i][j] = (i * 7 + j * 13) % 41 - 20;
    end
    run_stream("R4");

    // R1: extreme operands, widest sums
    for (int j = 0; j < N; j++) load_x(j, -128, "R1");
    nrows = 3;
    for (int j = 0; j < N; j++) begin A[0][j] = -128; A[1][j] = 127; A[2][j] = (j % 2) ? 127 : -128; end
    rs[0] = 0; rs[1] = 1; rs[2] = 2;
    run_stream("R1");

    // R5 / R6: rows with gaps, noise on idle lanes
    load_x(0, 11, "R7"); load_x(1, -9, "R7"); load_x(2, 4, "R7"); load_x(3, -1, "R7");
    nrows = 4;
    rs[0] = 0; rs[1] = 2; rs[2] = 3; rs[3] = 7;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < N; j++) A[i][j] = (i * 29 + j * 17) % 97 - 48;
    run_stream("R6");

    // R7: reload cell 1 on the edge where row 2 enters it
    nrows = 6;
    for (int i = 0; i < 6; i++) begin
      rs[i] = i;
      for (int j = 0; j < N; j++) A[i][j] = (i * 5 + j * 3) % 23 - 11;
    end
    ld_cyc = 3; ld_idx = 1; ld_val = 100;
    run_stream("R7");

    // R2: long back-to-back run with lane-distinct values
    nrows = 10;
    for (int i = 0; i < 10; i++) begin
      rs[i] = i;
      for (int j = 0; j < N; j++) A[i][j] = (j + 1) * 10 + i - 60;
    end
    run_stream("R2");

    // R8: reset clears stored vector, so results become zero
    do_reset();
    nrows = 2;
    rs[0] = 0; rs[1] = 1;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < N; j++) A[i][j] = 50 + i + j;
    last_y = 0;
    run_stream("R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule